// File: doc/BRIEF.md
# Privileged Status and Exception-Return Controller

This block holds the privileged control state of a small processor core: the status word, the cause word, the three return addresses (exception, error and debug), a four-bit enable mask for unprivileged hardware-register reads, the load-link address and a debug-mode flag. The core's pipeline drives it with one-cycle strobes. These request a register write, an exception entry, an exception return, a debug return, or an interrupt disable or enable. The block answers with a redirect address, a derived user-mode flag, an interrupt-take strobe and a permission verdict for hardware-register reads.

Each cycle, at most one operation is chosen by fixed priority: exception entry, then exception return, then debug return, then register write, then disable, then enable. All state changes take effect at the next rising clock edge. The redirect address, the old status value, the interrupt decision and the permission verdict are combinational outputs, formed from the state before that edge. A privilege classifier sorts the state into one of five levels, in this order: DEBUG (debug flag set), ERROR (ERL set), EXCEPT (EXL set), USER (UM set) and KERNEL (otherwise). The user-mode output and the interrupt decision are drawn from that level. Hardware interrupt lines are captured into the cause word on every clock.

Register select codes: 0 status, 1 cause, 2 exception PC, 3 error PC, 4 debug PC, 5 read-enable mask, 6 load-link address, 7 debug control (bit 30 is the debug-mode flag). Status bits: IE=0, EXL=1, ERL=2, UM=4, interrupt mask [15:8], CU0=28. Cause bits: pending [15:8] (software [9:8], hardware [15:10]), exception code [6:2].

Top module: `priv_status_ctl`

## Requirements
- R1: After reset, status reads 0x00000004 (ERL set), and cause, all three PCs, the read-enable mask, the load-link address and debug control read 0. User mode, interrupt take and pc_load are low.
- R2: A status write changes only the bits under mask 0xF878FF17; all other status bits keep their value.
- R3: A cause write changes only the bits under mask 0x00C00300 (this includes the software-pending bits [9:8]). Cause bits [15:10] follow irq_hw_i one clock later, and a cause write does not alter the exception code.
- R4: A write to the read-enable mask keeps only wdata[3:0]; the mask reads back zero-extended.
- R5: On exception return with ERL set, next_pc_o equals the error PC and pc_load_o is high in that cycle; ERL is then cleared and EXL is left unchanged.
- R6: On exception return with ERL clear, next_pc_o equals the exception PC; EXL is then cleared.
- R7: Debug return drives next_pc_o from the debug PC and then sets the debug-mode flag.
- R8: When exception return and debug return are both requested in one cycle, exception return is performed and the debug flag is unchanged.
- R9: After either exception return or debug return, the load-link address reads 1.
- R10: user_mode_o is high only when EXL, ERL and the debug flag are all clear and UM is set.
- R11: irq_take_o is high when EXL, ERL and the debug flag are clear, IE is set, and (status[15:8] & cause[15:8]) is nonzero. In that case the exception code is cleared at the next edge.
- R12: For disable or enable, old_status_o shows the status before the operation; IE is then cleared (disable) or set (enable).
- R13: For a hardware-register read of index k in user mode, hwr_grant_o is high when mask bit k or CU0 is set, and ri_exc_o is high otherwise. Outside user mode, the read is always granted.
- R14: Exception entry sets EXL, loads the exception PC from exc_pc_i and the exception code from exc_code_i. It takes priority over a return requested in the same cycle, so pc_load_o stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register select for read and write |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data of the selected register |
| eret_i | input | 1 | Exception return strobe |
| dret_i | input | 1 | Debug return strobe |
| di_i | input | 1 | Interrupt disable strobe |
| ei_i | input | 1 | Interrupt enable strobe |
| exc_raise_i | input | 1 | Exception entry strobe |
| exc_code_i | input | 5 | Exception code recorded on entry |
| exc_pc_i | input | 32 | Faulting PC recorded on entry |
| irq_hw_i | input | 6 | Hardware interrupt lines |
| hwr_req_i | input | 1 | Hardware-register read request |
| hwr_idx_i | input | 2 | Hardware-register index |
| next_pc_o | output | 32 | Redirect address on a return |
| pc_load_o | output | 1 | Redirect valid |
| old_status_o | output | 32 | Status before a disable or enable |
| user_mode_o | output | 1 | Derived user-mode flag |
| irq_take_o | output | 1 | External interrupt is to be taken |
| hwr_grant_o | output | 1 | Hardware-register read permitted |
| ri_exc_o | output | 1 | Reserved-instruction exception |

## Verification
The hardest state to reach is one where the exception code is nonzero and an interrupt becomes takeable at the same time. The code can only be set by exception entry, and entry also sets EXL, which blocks the interrupt. The stimulus therefore raises an exception with a known code, writes status to clear EXL while enabling IE and one mask bit that matches a software-pending bit, and then watches the code drop on the following edge. A second path reaches the interrupt through a hardware line, whose capture takes one clock.

// File: rtl/psc_pkg.sv
package psc_pkg;
    localparam int DW        = 32;
    localparam int AW        = 3;
    localparam int HW_IRQ    = 6;
    localparam int HWR_N     = 4;
    localparam int HWR_IDX_W = $clog2(HWR_N);
    localparam int CODE_W    = 5;
    localparam int PEND_W    = 8;

    localparam logic [DW-1:0] STATUS_WMASK = 32'hF878_FF17;
    localparam logic [DW-1:0] CAUSE_WMASK  = 32'h00C0_0300;
    localparam logic [DW-1:0] STATUS_RST   = 32'h0000_0004;
    localparam logic [DW-1:0] LINK_DEAD    = 32'h0000_0001;

    localparam int ST_IE   = 0;
    localparam int ST_EXL  = 1;
    localparam int ST_ERL  = 2;
    localparam int ST_UM   = 4;
    localparam int ST_CU0  = 28;
    localparam int IM_LO   = 8;
    localparam int IP_LO   = 8;
    localparam int IPHW_LO = IP_LO + 2;
    localparam int CODE_LO = 2;
    localparam int DBG_DM  = 30;

    typedef enum logic [AW-1:0] {
        SEL_STATUS = 3'd0,
        SEL_CAUSE  = 3'd1,
        SEL_EPC    = 3'd2,
        SEL_ERRPC  = 3'd3,
        SEL_DEPC   = 3'd4,
        SEL_HWENA  = 3'd5,
        SEL_LINK   = 3'd6,
        SEL_DBG    = 3'd7
    } reg_sel_e;

    typedef enum logic [2:0] {
        OP_IDLE, OP_RAISE, OP_ERET, OP_DRET, OP_WRITE, OP_DI, OP_EI
    } op_e;

    typedef enum logic [2:0] {
        PRIV_DEBUG, PRIV_ERROR, PRIV_EXCEPT, PRIV_KERNEL, PRIV_USER
    } priv_e;
endpackage

// File: rtl/psc_op_arbiter.sv
module psc_op_arbiter
    import psc_pkg::*;
(
    input  logic reg_we_i,
    input  logic eret_i,
    input  logic dret_i,
    input  logic di_i,
    input  logic ei_i,
    input  logic exc_raise_i,
    output op_e  op_o
);
    always_comb begin
        if (exc_raise_i)   op_o = OP_RAISE;
        else if (eret_i)   op_o = OP_ERET;
        else if (dret_i)   op_o = OP_DRET;
        else if (reg_we_i) op_o = OP_WRITE;
        else if (di_i)     op_o = OP_DI;
        else if (ei_i)     op_o = OP_EI;
        else               op_o = OP_IDLE;
    end
endmodule

// File: rtl/psc_regs.sv
module psc_regs
    import psc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  op_e               op_i,
    input  reg_sel_e          sel_i,
    input  logic [DW-1:0]     wdata_i,
    input  logic [CODE_W-1:0] exc_code_i,
    input  logic [DW-1:0]     exc_pc_i,
    input  logic [HW_IRQ-1:0] irq_hw_i,
    input  logic              irq_take_i,
    output logic [DW-1:0]     status_o,
    output logic [DW-1:0]     cause_o,
    output logic [DW-1:0]     epc_o,
    output logic [DW-1:0]     errpc_o,
    output logic [DW-1:0]     depc_o,
    output logic [HWR_N-1:0]  hwena_o,
    output logic [DW-1:0]     link_o,
    output logic              dm_o
);
    logic [DW-1:0]    status_q, status_d;
    logic [DW-1:0]    cause_q, cause_d;
    logic [DW-1:0]    epc_q, epc_d;
    logic [DW-1:0]    errpc_q, errpc_d;
    logic [DW-1:0]    depc_q, depc_d;
    logic [HWR_N-1:0] hwena_q, hwena_d;
    logic [DW-1:0]    link_q, link_d;
    logic             dm_q, dm_d;

    always_comb begin
        status_d = status_q;
        cause_d  = cause_q;
        epc_d    = epc_q;
        errpc_d  = errpc_q;
        depc_d   = depc_q;
        hwena_d  = hwena_q;
        link_d   = link_q;
        dm_d     = dm_q;
        if (irq_take_i) cause_d[CODE_LO +: CODE_W] = '0;
        unique case (op_i)
            OP_RAISE: begin
                status_d[ST_EXL]           = 1'b1;
                epc_d                      = exc_pc_i;
                cause_d[CODE_LO +: CODE_W] = exc_code_i;
            end
            OP_ERET: begin
                if (status_q[ST_ERL]) status_d[ST_ERL] = 1'b0;
                else                  status_d[ST_EXL] = 1'b0;
                link_d = LINK_DEAD;
            end
            OP_DRET: begin
                dm_d   = 1'b1;
                link_d = LINK_DEAD;
            end
            OP_WRITE: begin
                unique case (sel_i)
                    SEL_STATUS: status_d = (status_q & ~STATUS_WMASK) | (wdata_i & STATUS_WMASK);
                    SEL_CAUSE:  cause_d  = (cause_d & ~CAUSE_WMASK) | (wdata_i & CAUSE_WMASK);
                    SEL_EPC:    epc_d    = wdata_i;
                    SEL_ERRPC:  errpc_d  = wdata_i;
                    SEL_DEPC:   depc_d   = wdata_i;
                    SEL_HWENA:  hwena_d  = wdata_i[HWR_N-1:0];
                    SEL_LINK:   link_d   = wdata_i;
                    SEL_DBG:    dm_d     = wdata_i[DBG_DM];
                endcase
            end
            OP_DI:   status_d[ST_IE] = 1'b0;
            OP_EI:   status_d[ST_IE] = 1'b1;
            OP_IDLE: ;
        endcase
        cause_d[IPHW_LO +: HW_IRQ] = irq_hw_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= STATUS_RST;
            cause_q  <= '0;
            epc_q    <= '0;
            errpc_q  <= '0;
            depc_q   <= '0;
            hwena_q  <= '0;
            link_q   <= '0;
            dm_q     <= 1'b0;
        end else begin
            status_q <= status_d;
            cause_q  <= cause_d;
            epc_q    <= epc_d;
            errpc_q  <= errpc_d;
            depc_q   <= depc_d;
            hwena_q  <= hwena_d;
            link_q   <= link_d;
            dm_q     <= dm_d;
        end
    end

    assign status_o = status_q;
    assign cause_o  = cause_q;
    assign epc_o    = epc_q;
    assign errpc_o  = errpc_q;
    assign depc_o   = depc_q;
    assign hwena_o  = hwena_q;
    assign link_o   = link_q;
    assign dm_o     = dm_q;

    // R2: unmasked status bits survive a status write
    p_status_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_WRITE && sel_i == SEL_STATUS) |=>
        ((status_q & ~STATUS_WMASK) == ($past(status_q) & ~STATUS_WMASK)));

    // R5: ERL is served first and EXL is left alone
    p_erl_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_ERET && status_q[ST_ERL]) |=>
        (!status_q[ST_ERL] && status_q[ST_EXL] == $past(status_q[ST_EXL])));

    // R6: without ERL the return drops EXL
    p_exl_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_ERET && !status_q[ST_ERL]) |=> !status_q[ST_EXL]);

    // R7: debug return enters debug mode
    p_dret_dm_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_DRET) |=> dm_q);

    // R9: any return kills the link
    p_link_dead_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_ERET || op_i == OP_DRET) |=> (link_q == LINK_DEAD));

    // R11: a taken interrupt wipes the exception code
    p_code_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_take_i && op_i != OP_RAISE) |=> (cause_q[CODE_LO +: CODE_W] == '0));

    // R12: disable and enable act on IE
    p_di_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_DI) |=> !status_q[ST_IE]);
    p_ei_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_EI) |=> status_q[ST_IE]);

    // R14: exception entry records the PC
    p_raise_epc_r14: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_RAISE) |=> (status_q[ST_EXL] && epc_q == $past(exc_pc_i)));
endmodule

// File: rtl/psc_eval.sv
module psc_eval
    import psc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  op_e                  op_i,
    input  logic [DW-1:0]        status_i,
    input  logic [PEND_W-1:0]    pend_i,
    input  logic [DW-1:0]        epc_i,
    input  logic [DW-1:0]        errpc_i,
    input  logic [DW-1:0]        depc_i,
    input  logic [HWR_N-1:0]     hwena_i,
    input  logic                 dm_i,
    input  logic                 hwr_req_i,
    input  logic [HWR_IDX_W-1:0] hwr_idx_i,
    output logic [DW-1:0]        next_pc_o,
    output logic                 pc_load_o,
    output logic [DW-1:0]        old_status_o,
    output logic                 user_mode_o,
    output logic                 irq_take_o,
    output logic                 hwr_grant_o,
    output logic                 ri_exc_o
);
    priv_e priv;
    logic  irq_open;
    logic  pend_hit;
    logic  hwr_ok;

    always_comb begin
        if (dm_i)                  priv = PRIV_DEBUG;
        else if (status_i[ST_ERL]) priv = PRIV_ERROR;
        else if (status_i[ST_EXL]) priv = PRIV_EXCEPT;
        else if (status_i[ST_UM])  priv = PRIV_USER;
        else                       priv = PRIV_KERNEL;
    end

    always_comb begin
        unique case (priv)
            PRIV_USER:   begin user_mode_o = 1'b1; irq_open = 1'b1; end
            PRIV_KERNEL: begin user_mode_o = 1'b0; irq_open = 1'b1; end
            PRIV_DEBUG, PRIV_ERROR, PRIV_EXCEPT:
                         begin user_mode_o = 1'b0; irq_open = 1'b0; end
            default:     begin user_mode_o = 1'b0; irq_open = 1'b0; end
        endcase
    end

    assign pend_hit   = |(status_i[IM_LO +: PEND_W] & pend_i);
    assign irq_take_o = irq_open && status_i[ST_IE] && pend_hit;

    always_comb begin
        next_pc_o    = '0;
        pc_load_o    = 1'b0;
        old_status_o = '0;
        unique case (op_i)
            OP_ERET: begin
                pc_load_o = 1'b1;
                next_pc_o = status_i[ST_ERL] ? errpc_i : epc_i;
            end
            OP_DRET: begin
                pc_load_o = 1'b1;
                next_pc_o = depc_i;
            end
            OP_DI, OP_EI: old_status_o = status_i;
            OP_IDLE, OP_RAISE, OP_WRITE: ;
            default: ;
        endcase
    end

    assign hwr_ok      = !user_mode_o || hwena_i[hwr_idx_i] || status_i[ST_CU0];
    assign hwr_grant_o = hwr_req_i && hwr_ok;
    assign ri_exc_o    = hwr_req_i && !hwr_ok;

    // R13: grant and fault never together
    p_hwr_excl_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !(hwr_grant_o && ri_exc_o));

    // R10: user mode never overlaps debug mode
    p_user_nodebug_r10: assert property (@(posedge clk) disable iff (!rst_n)
        user_mode_o |-> !dm_i);

    // R11: no interrupt inside exception, error or debug context
    p_take_ctx_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take_o |-> (!dm_i && !status_i[ST_EXL] && !status_i[ST_ERL]));

    // R14: entry suppresses any redirect
    p_raise_nopc_r14: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_RAISE) |-> !pc_load_o);
endmodule

// File: rtl/priv_status_ctl.sv
module priv_status_ctl
    import psc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_we_i,
    input  logic [AW-1:0]        reg_addr_i,
    input  logic [DW-1:0]        reg_wdata_i,
    output logic [DW-1:0]        reg_rdata_o,
    input  logic                 eret_i,
    input  logic                 dret_i,
    input  logic                 di_i,
    input  logic                 ei_i,
    input  logic                 exc_raise_i,
    input  logic [CODE_W-1:0]    exc_code_i,
    input  logic [DW-1:0]        exc_pc_i,
    input  logic [HW_IRQ-1:0]    irq_hw_i,
    input  logic                 hwr_req_i,
    input  logic [HWR_IDX_W-1:0] hwr_idx_i,
    output logic [DW-1:0]        next_pc_o,
    output logic                 pc_load_o,
    output logic [DW-1:0]        old_status_o,
    output logic                 user_mode_o,
    output logic                 irq_take_o,
    output logic                 hwr_grant_o,
    output logic                 ri_exc_o
);
    op_e              op;
    reg_sel_e         sel;
    logic [DW-1:0]    status, cause, epc, errpc, depc, link;
    logic [HWR_N-1:0] hwena;
    logic             dm;

    assign sel = reg_sel_e'(reg_addr_i);

    psc_op_arbiter u_arb (
        .reg_we_i    (reg_we_i),
        .eret_i      (eret_i),
        .dret_i      (dret_i),
        .di_i        (di_i),
        .ei_i        (ei_i),
        .exc_raise_i (exc_raise_i),
        .op_o        (op)
    );

    psc_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_i       (op),
        .sel_i      (sel),
        .wdata_i    (reg_wdata_i),
        .exc_code_i (exc_code_i),
        .exc_pc_i   (exc_pc_i),
        .irq_hw_i   (irq_hw_i),
        .irq_take_i (irq_take_o),
        .status_o   (status),
        .cause_o    (cause),
        .epc_o      (epc),
        .errpc_o    (errpc),
        .depc_o     (depc),
        .hwena_o    (hwena),
        .link_o     (link),
        .dm_o       (dm)
    );

    psc_eval u_eval (
        .clk          (clk),
        .rst_n        (rst_n),
        .op_i         (op),
        .status_i     (status),
        .pend_i       (cause[IP_LO +: PEND_W]),
        .epc_i        (epc),
        .errpc_i      (errpc),
        .depc_i       (depc),
        .hwena_i      (hwena),
        .dm_i         (dm),
        .hwr_req_i    (hwr_req_i),
        .hwr_idx_i    (hwr_idx_i),
        .next_pc_o    (next_pc_o),
        .pc_load_o    (pc_load_o),
        .old_status_o (old_status_o),
        .user_mode_o  (user_mode_o),
        .irq_take_o   (irq_take_o),
        .hwr_grant_o  (hwr_grant_o),
        .ri_exc_o     (ri_exc_o)
    );

    always_comb begin
        unique case (sel)
            SEL_STATUS: reg_rdata_o = status;
            SEL_CAUSE:  reg_rdata_o = cause;
            SEL_EPC:    reg_rdata_o = epc;
            SEL_ERRPC:  reg_rdata_o = errpc;
            SEL_DEPC:   reg_rdata_o = depc;
            SEL_HWENA:  reg_rdata_o = {{(DW-HWR_N){1'b0}}, hwena};
            SEL_LINK:   reg_rdata_o = link;
            SEL_DBG:    reg_rdata_o = {{(DW-DBG_DM-1){1'b0}}, dm, {DBG_DM{1'b0}}};
        endcase
    end

    // R8: a debug return that loses to an exception return leaves debug mode as it was
    p_eret_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (eret_i && dret_i && !exc_raise_i) |=> $stable(dm));
endmodule

// File: tb/priv_status_ctl_bench.sv
module priv_status_ctl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 11;

    // {select, write data, expected readback}
    localparam logic [66:0] VEC [0:NVEC-1] = '{
        {3'd0, 32'hFFFF_FFFF, 32'hF878_FF17},   // R2
        {3'd0, 32'h0000_0000, 32'h0000_0000},   // R2
        {3'd1, 32'hFFFF_FFFF, 32'h00C0_0300},   // R3
        {3'd1, 32'h1234_5678, 32'h0000_0200},   // R3
        {3'd5, 32'hFFFF_FFF5, 32'h0000_0005},   // R4
        {3'd2, 32'h8000_0180, 32'h8000_0180},
        {3'd3, 32'hBFC0_0000, 32'hBFC0_0000},
        {3'd4, 32'h0000_1234, 32'h0000_1234},
        {3'd6, 32'hDEAD_BEEF, 32'hDEAD_BEEF},
        {3'd7, 32'h4000_0000, 32'h4000_0000},
        {3'd7, 32'h0000_0000, 32'h0000_0000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        eret = 1'b0, dret = 1'b0, di = 1'b0, ei = 1'b0, raise = 1'b0;
    logic [4:0]  exc_code = '0;
    logic [31:0] exc_pc = '0;
    logic [5:0]  irq_hw = '0;
    logic        hwr_req = 1'b0;
    logic [1:0]  hwr_idx = '0;
    logic [31:0] next_pc, old_status;
    logic        pc_load, user_mode, irq_take, hwr_grant, ri_exc;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    priv_status_ctl u_priv_status_ctl (
        .clk(clk), .rst_n(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
        .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .eret_i(eret),
        .dret_i(dret), .di_i(di), .ei_i(ei), .exc_raise_i(raise),
        .exc_code_i(exc_code), .exc_pc_i(exc_pc), .irq_hw_i(irq_hw),
        .hwr_req_i(hwr_req), .hwr_idx_i(hwr_idx), .next_pc_o(next_pc),
        .pc_load_o(pc_load), .old_status_o(old_status), .user_mode_o(user_mode),
        .irq_take_o(irq_take), .hwr_grant_o(hwr_grant), .ri_exc_o(ri_exc)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic ops(input logic e, input logic d, input logic i, input logic n, input logic r);
        eret = e; dret = d; di = i; ei = n; raise = r;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(3'd0, v); chk("R1 status", v, 32'h4);
        rd(3'd1, v); chk("R1 cause", v, 32'h0);
        rd(3'd5, v); chk("R1 mask", v, 32'h0);
        rd(3'd6, v); chk("R1 link", v, 32'h0);
        rd(3'd7, v); chk("R1 debug", v, 32'h0);
        chk("R1 flags", {29'd0, user_mode, irq_take, pc_load}, 32'h0);

        // table of write / readback vectors (R2 R3 R4)
        for (int i = 0; i < NVEC; i++) begin
            wr(VEC[i][66:64], VEC[i][63:32]);
            rd(VEC[i][66:64], v);
            chk($sformatf("R2/R3/R4 vector %0d", i), v, VEC[i][31:0]);
        end

        // R10 user-mode derivation
        wr(3'd0, 32'h10); #1; chk("R10 UM only", {31'd0, user_mode}, 32'd1);
        wr(3'd0, 32'h12); #1; chk("R10 EXL blocks", {31'd0, user_mode}, 32'd0);
        wr(3'd0, 32'h14); #1; chk("R10 ERL blocks", {31'd0, user_mode}, 32'd0);
        wr(3'd0, 32'h10);
        wr(3'd7, 32'h4000_0000); #1; chk("R10 debug blocks", {31'd0, user_mode}, 32'd0);
        wr(3'd7, 32'h0); #1; chk("R10 debug off", {31'd0, user_mode}, 32'd1);

        // R13 hardware-register permission, mask = 0x5
        hwr_req = 1'b1;
        hwr_idx = 2'd0; #1; chk("R13 idx0 grant", {30'd0, hwr_grant, ri_exc}, 32'h2);
        hwr_idx = 2'd1; #1; chk("R13 idx1 fault", {30'd0, hwr_grant, ri_exc}, 32'h1);
        hwr_idx = 2'd3; #1; chk("R13 idx3 fault", {30'd0, hwr_grant, ri_exc}, 32'h1);
        wr(3'd0, 32'h1000_0010);
        hwr_idx = 2'd1; #1; chk("R13 CU0 grant", {30'd0, hwr_grant, ri_exc}, 32'h2);
        wr(3'd0, 32'h0);
        hwr_idx = 2'd3; #1; chk("R13 kernel grant", {30'd0, hwr_grant, ri_exc}, 32'h2);
        hwr_req = 1'b0;

        // R5 / R6 / R9 exception return sequencing
        wr(3'd0, 32'h6);
        @(negedge clk); ops(1, 0, 0, 0, 0); #1;
        chk("R5 pc from error PC", next_pc, 32'hBFC0_0000);
        chk("R5 pc_load", {31'd0, pc_load}, 32'd1);
        @(negedge clk); ops(0, 0, 0, 0, 0);
        rd(3'd0, v); chk("R5 ERL cleared EXL kept", v, 32'h2);
        rd(3'd6, v); chk("R9 link after eret", v, 32'h1);
        @(negedge clk); ops(1, 0, 0, 0, 0); #1;
        chk("R6 pc from exception PC", next_pc, 32'h8000_0180);
        @(negedge clk); ops(0, 0, 0, 0, 0);
        rd(3'd0, v); chk("R6 EXL cleared", v, 32'h0);

        // R7 / R9 debug return
        wr(3'd6, 32'hDEAD_BEEF);
        @(negedge clk); ops(0, 1, 0, 0, 0); #1;
        chk("R7 pc from debug PC", next_pc, 32'h0000_1234);
        @(negedge clk); ops(0, 0, 0, 0, 0);
        rd(3'd7, v); chk("R7 debug set", v, 32'h4000_0000);
        rd(3'd6, v); chk("R9 link after dret", v, 32'h1);
        wr(3'd7, 32'h0);

        // R8 both returns together
        wr(3'd0, 32'h2);
        wr(3'd6, 32'h55);
        @(negedge clk); ops(1, 1, 0, 0, 0); #1;
        chk("R8 eret pc wins", next_pc, 32'h8000_0180);
        @(negedge clk); ops(0, 0, 0, 0, 0);
        rd(3'd7, v); chk("R8 debug unchanged", v, 32'h0);
        rd(3'd0, v); chk("R8 EXL cleared", v, 32'h0);
        rd(3'd6, v); chk("R9 link after both", v, 32'h1);

        // R14 exception entry beats a return
        @(negedge clk); ops(1, 0, 0, 0, 1); exc_code = 5'h0A; exc_pc = 32'h100; #1;
        chk("R14 no redirect", {31'd0, pc_load}, 32'd0);
        @(negedge clk); ops(0, 0, 0, 0, 0);
        rd(3'd0, v); chk("R14 EXL set", v, 32'h2);
        rd(3'd2, v); chk("R14 EPC loaded", v, 32'h100);
        rd(3'd1, v); chk("R14 code loaded", v, 32'h228);

        // R11 interrupt decision and code clearing
        wr(3'd0, 32'h203); #1; chk("R11 blocked by EXL", {31'd0, irq_take}, 32'd0);
        wr(3'd0, 32'h201); #1; chk("R11 software pending taken", {31'd0, irq_take}, 32'd1);
        rd(3'd1, v); chk("R11 code before edge", v, 32'h228);
        @(negedge clk);
        rd(3'd1, v); chk("R11 code cleared", v, 32'h200);
        wr(3'd0, 32'h401); #1; chk("R11 mask mismatch", {31'd0, irq_take}, 32'd0);
        irq_hw = 6'b000001;
        @(negedge clk);
        rd(3'd1, v); chk("R3 hardware line captured", v, 32'h600);
        chk("R11 hardware pending taken", {31'd0, irq_take}, 32'd1);
        irq_hw = 6'b0;
        wr(3'd0, 32'h0);

        // R12 disable / enable
        wr(3'd0, 32'h10);
        @(negedge clk); ops(0, 0, 0, 1, 0); #1;
        chk("R12 old status on enable", old_status, 32'h10);
        @(negedge clk); ops(0, 0, 0, 0, 0);
        rd(3'd0, v); chk("R12 IE set", v, 32'h11);
        @(negedge clk); ops(0, 0, 1, 0, 0); #1;
        chk("R12 old status on disable", old_status, 32'h11);
        @(negedge clk); ops(0, 0, 0, 0, 0);
        rd(3'd0, v); chk("R12 IE cleared", v, 32'h10);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule